// File: doc/BRIEF.md
# Dual Baud Clock Generator

This block derives two independent 16x oversampling clocks, one for a transmitter and one for a receiver, from a single 5.0688 MHz reference. Each channel has its own 4-bit rate code, captured into a per-channel select register whenever that channel's load strobe is high on a reference clock edge. A fixed table maps each code to a divisor, and the selected rate is sixteen times a standard baud rate.

Each channel provides two outputs. The first is a one-reference-cycle enable pulse, issued once per divisor period. The second is a registered square wave at the same rate. A new code never cuts short a period that is already running. The channel takes up the new divisor only when its counter next reloads.

Top module: `baud_pair_gen`

## Requirements
- R1: While rst_ni is low, all tick and square outputs are 0. After reset, both channels run with code 0000, so their tick period is 6336 reference cycles.
- R2: For codes 0000 to 0111, the tick period in reference cycles is 6336, 4224, 2880, 2355, 2112, 1056, 528 and 264 respectively. Code 0101 gives 1056 cycles, which is a 4.8 kHz tick (16 x 300 baud).
- R3: For codes 1000 to 1111, the tick period in reference cycles is 176, 158, 132, 88, 66, 44, 33 and 16 respectively.
- R4: A tick output is high for exactly one reference cycle per period.
- R5: In every period of divisor D, the square output is high for floor(D/2) cycles. It rises in the same cycle as the tick and falls in a cycle without a tick.
- R6: The select code is captured on a clock edge where the channel strobe is 1. While the strobe is 0, changes on the select input have no effect on the output rate.
- R7: With the strobe held at 1, the select register follows the select input, so a changed input alters the rate without any further strobe.
- R8: A code loaded in the middle of a period does not alter that period. The new divisor applies from the next counter reload onward.
- R9: The two channels are independent. Loading a code into one channel does not change the other channel's period.
- R10: The gap between consecutive ticks on either channel never exceeds 6336 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (5.0688 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_sel_i | input | 4 | Transmit rate code |
| tx_stb_i | input | 1 | Transmit code load strobe, active high |
| rx_sel_i | input | 4 | Receive rate code |
| rx_stb_i | input | 1 | Receive code load strobe, active high |
| tx_tick_o | output | 1 | Transmit 16x enable pulse |
| tx_sq_o | output | 1 | Transmit 16x square wave |
| rx_tick_o | output | 1 | Receive 16x enable pulse |
| rx_sq_o | output | 1 | Receive 16x square wave |

## Verification
A strobed code lands in the select register at the clock edge that samples the strobe. It reaches the outputs only at the counter reload after that edge. The tick and the square-wave rise then appear in the cycle that follows the reload edge, and the next tick comes exactly one divisor later. For this reason, the bench always waits for two ticks after a load before it measures a period. The only exception is the test that deliberately loads in mid-period, to show that the running period keeps its old length. All outputs are sampled on the falling clock edge. Periods and high-phase lengths are counted from one sampled tick to the next.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned CNT_W = 13;
  localparam int unsigned DIV_MAX = 6336;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // 16x baud divisors for a 5.0688 MHz reference
  function automatic cnt_t div_of(input sel_t code);
    case (code)
      4'd0:    return cnt_t'(6336);
      4'd1:    return cnt_t'(4224);
      4'd2:    return cnt_t'(2880);
      4'd3:    return cnt_t'(2355);
      4'd4:    return cnt_t'(2112);
      4'd5:    return cnt_t'(1056);
      4'd6:    return cnt_t'(528);
      4'd7:    return cnt_t'(264);
      4'd8:    return cnt_t'(176);
      4'd9:    return cnt_t'(158);
      4'd10:   return cnt_t'(132);
      4'd11:   return cnt_t'(88);
      4'd12:   return cnt_t'(66);
      4'd13:   return cnt_t'(44);
      4'd14:   return cnt_t'(33);
      default: return cnt_t'(16);
    endcase
  endfunction
endpackage

// File: rtl/baud_sel_reg.sv
module baud_sel_reg
  import baud_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  sel_t sel_i,
  output sel_t sel_o
);
  sel_t sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= '0;
    else if (stb_i) sel_q <= sel_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/baud_chan_div.sv
module baud_chan_div
  import baud_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t sel_i,
  output logic tick_o,
  output logic sq_o
);
  cnt_t cnt_q, cnt_d;
  cnt_t div_q, div_d;
  logic reload;
  logic sq_d;

  // divisor is sampled only on reload: no runt periods
  always_comb begin
    reload = (cnt_q == '0);
    div_d  = reload ? div_of(sel_i) : div_q;
    cnt_d  = reload ? div_d - cnt_t'(1) : cnt_q - cnt_t'(1);
    sq_d   = (cnt_d >= (div_d - (div_d >> 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= div_of('0);
      tick_o <= 1'b0;
      sq_o   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      tick_o <= reload;
      sq_o   <= sq_d;
    end
  end
endmodule

// File: rtl/baud_pair_gen.sv
module baud_pair_gen
  import baud_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] tx_sel_i,
  input  logic       tx_stb_i,
  input  logic [3:0] rx_sel_i,
  input  logic       rx_stb_i,
  output logic       tx_tick_o,
  output logic       tx_sq_o,
  output logic       rx_tick_o,
  output logic       rx_sq_o
);
  localparam int unsigned N_CH = 2;

  sel_t sel_in  [N_CH];
  sel_t sel_reg [N_CH];
  logic stb_in  [N_CH];
  logic tick    [N_CH];
  logic sq      [N_CH];

  assign sel_in[0] = tx_sel_i;
  assign sel_in[1] = rx_sel_i;
  assign stb_in[0] = tx_stb_i;
  assign stb_in[1] = rx_stb_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    baud_sel_reg i_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (stb_in[c]),
      .sel_i  (sel_in[c]),
      .sel_o  (sel_reg[c])
    );
    baud_chan_div i_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel_reg[c]),
      .tick_o (tick[c]),
      .sq_o   (sq[c])
    );
  end

  assign tx_tick_o = tick[0];
  assign tx_sq_o   = sq[0];
  assign rx_tick_o = tick[1];
  assign rx_sq_o   = sq[1];
endmodule

// File: rtl/baud_pair_gen_chk.sv
module baud_pair_gen_chk
  import baud_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic tx_tick_i,
  input logic tx_sq_i,
  input logic rx_tick_i,
  input logic rx_sq_i
);
  cnt_t tx_gap_q, rx_gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_gap_q <= '0;
      rx_gap_q <= '0;
    end else begin
      tx_gap_q <= tx_tick_i ? '0 : tx_gap_q + cnt_t'(1);
      rx_gap_q <= rx_tick_i ? '0 : rx_gap_q + cnt_t'(1);
    end
  end

  assert_tx_tick_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_i |=> !tx_tick_i);
  assert_rx_tick_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_tick_i |=> !rx_tick_i);
  assert_tx_sq_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_sq_i) |-> tx_tick_i);
  assert_rx_sq_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_sq_i) |-> rx_tick_i);
  assert_tx_sq_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_sq_i) |-> !tx_tick_i);
  assert_rx_sq_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_sq_i) |-> !rx_tick_i);
  assert_tx_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_gap_q < cnt_t'(DIV_MAX));
  assert_rx_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_gap_q < cnt_t'(DIV_MAX));
endmodule

bind baud_pair_gen baud_pair_gen_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_tick_i (tx_tick_o),
  .tx_sq_i   (tx_sq_o),
  .rx_tick_i (rx_tick_o),
  .rx_sq_i   (rx_sq_o)
);

// File: tb/test_baud_pair_gen.sv
`timescale 1ns/1ps
module test_baud_pair_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_sel = '0, rx_sel = '0;
  logic       tx_stb = 1'b0, rx_stb = 1'b0;
  logic       tx_tick, tx_sq, rx_tick, rx_sq;
  int         n_vec = 0, n_err = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  baud_pair_gen i_baud_pair_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_sel_i(tx_sel), .tx_stb_i(tx_stb),
    .rx_sel_i(rx_sel), .rx_stb_i(rx_stb),
    .tx_tick_o(tx_tick), .tx_sq_o(tx_sq),
    .rx_tick_o(rx_tick), .rx_sq_o(rx_sq)
  );

  function automatic int exp_div(input int code);
    int t[16] = '{6336, 4224, 2880, 2355, 2112, 1056, 528, 264,
                  176, 158, 132, 88, 66, 44, 33, 16};
    return t[code];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int ch);
    do @(negedge clk); while (!(ch == 0 ? tx_tick : rx_tick));
  endtask

  task automatic meas(input int ch, output int per, output int hi);
    wait_tick(ch);
    per = 0; hi = 0;
    do begin
      if (ch == 0 ? tx_sq : rx_sq) hi++;
      per++;
      @(negedge clk);
    end while (!(ch == 0 ? tx_tick : rx_tick));
  endtask

  task automatic load(input int ch, input int code);
    @(negedge clk);
    if (ch == 0) begin tx_sel = 4'(code); tx_stb = 1'b1; end
    else         begin rx_sel = 4'(code); rx_stb = 1'b1; end
    @(negedge clk);
    tx_stb = 1'b0; rx_stb = 1'b0;
    wait_tick(ch); wait_tick(ch);
  endtask

  task automatic t_reset;
    int per, hi;
    @(negedge clk);
    chk("R1 tx_tick in reset", int'(tx_tick), 0);
    chk("R1 tx_sq in reset",   int'(tx_sq), 0);
    chk("R1 rx_tick in reset", int'(rx_tick), 0);
    chk("R1 rx_sq in reset",   int'(rx_sq), 0);
    rst_n = 1'b1;
    meas(0, per, hi);
    chk("R1 tx default period", per, 6336);
    meas(1, per, hi);
    chk("R1 rx default period", per, 6336);
  endtask

  task automatic t_sweep;
    int per, hi;
    for (int c = 0; c < 16; c++) begin
      load(0, c);
      meas(0, per, hi);
      chk(c < 8 ? "R2 period" : "R3 period", per, exp_div(c));
      chk("R5 high phase", hi, exp_div(c) / 2);
    end
  endtask

  task automatic t_hold;
    int per, hi;
    load(0, 15);
    @(negedge clk); tx_sel = 4'd0;
    meas(0, per, hi);
    chk("R6 strobe low ignored", per, 16);
    meas(0, per, hi);
    chk("R6 strobe low ignored again", per, 16);
  endtask

  task automatic t_follow;
    int per, hi;
    @(negedge clk); tx_stb = 1'b1; tx_sel = 4'd14;
    wait_tick(0); wait_tick(0);
    meas(0, per, hi);
    chk("R7 follow code 14", per, 33);
    tx_sel = 4'd13;
    wait_tick(0); wait_tick(0);
    meas(0, per, hi);
    chk("R7 follow code 13", per, 44);
    tx_stb = 1'b0;
  endtask

  task automatic t_no_runt;
    int per, hi;
    load(0, 8);
    wait_tick(0);
    per = 0;
    do begin
      per++;
      if (per == 50) begin tx_sel = 4'd15; tx_stb = 1'b1; end
      else tx_stb = 1'b0;
      @(negedge clk);
    end while (!tx_tick);
    tx_stb = 1'b0;
    chk("R8 running period kept", per, 176);
    meas(0, per, hi);
    chk("R8 new period after reload", per, 16);
  endtask

  task automatic t_indep;
    int per, hi;
    load(1, 12);
    load(0, 11);
    meas(1, per, hi);
    chk("R9 rx period", per, 66);
    chk("R9 rx high phase", hi, 33);
    meas(0, per, hi);
    chk("R9 tx period", per, 88);
    load(1, 5);
    meas(0, per, hi);
    chk("R9 tx kept after rx load", per, 88);
    meas(1, per, hi);
    chk("R2 rx 4.8 kHz code", per, 1056);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_follow();
    t_no_runt();
    t_indep();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_vec++; n_err++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule